// File: doc/BRIEF.md
# Rotating Survivor Memory with Traceback and Decode

This block keeps the survivor decisions of a hard-decision Viterbi decoder. The decoder uses four trellis states, which come from a constraint-length-3, rate-1/2 code. On every trellis step the add-compare-select stage gives it two things: a 4-bit decision vector, with one bit per state, and the index of the state that currently has the best metric. The block turns these into a serial stream of decoded bits. Each bit comes with a one-cycle valid strobe.

Storage is three banks. Each bank has one row per state and one column per time step, and is D columns wide (D = 15 by default). On every step, three jobs run at once, each on a different bank:

- The write bank stores the incoming vector.
- The traceback bank is walked backward from the best state to find where decoding should start.
- The decode bank is walked backward from that start point, and one decoded bit is taken out on each step.

The three roles rotate every D steps, so the banks are reused in a cycle. A D-bit reorder buffer turns the backward-read bits back into time order before they leave the block.

Top module: `survivor_tb_mem`

## Requirements
- R1: After reset `out_valid` and `out_bit` are 0. No strobe appears during the first 3·D steps, while the banks and the reorder buffer fill.
- R2: From step 3·D onward, every cycle with `step_en` high is followed in the next cycle by exactly one cycle of `out_valid` high. `out_valid` is never high in any other cycle.
- R3: Bit i of `dec_vec` is the decision for state i, where state i means `best_state`/state value i. It is stored in the column of the write bank that equals the step's position (0 to D-1) within the current period.
- R4: The traceback starts from the `best_state` presented on the first step of a period. It walks the bank filled in the previous period, from column D-1 down to column 0, one column per step. The next state is formed from the current 2-bit state s and the stored decision bit d as {d, s[1]}.
- R5: The decode walk of a bank starts from the state that its traceback ended in. The walk uses the same rule as R4. The decoded bit for each column is the MSB of the state held before that column is applied.
- R6: The decoded bits of the data written in period p are emitted during period p+3 in forward time order. The bit for column 0 comes first.
- R7: Bank roles rotate every D steps: the write bank becomes the traceback bank, the traceback bank becomes the decode bank, and the decode bank becomes the write bank.
- R8: In a cycle with `step_en` low, nothing is written, no walk advances, and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | One trellis step is taken in this cycle |
| dec_vec | input | 4 | Decision bits, bit i for state i |
| best_state | input | 2 | Index of the best-metric state for this step |
| out_bit | output | 1 | Decoded bit |
| out_valid | output | 1 | One-cycle strobe qualifying `out_bit` |

## Verification
On the last step of a period, three things happen in the same cycle:

- the decode walk reads column 0 of its bank;
- the reorder buffer is handed to the output side;
- the bank roles rotate, so the bank just decoded becomes the next write target.

The bench crosses many such boundaries, with idle cycles mixed in. It compares every strobed bit against a reference walk computed from the stimulus history. An off-by-one error in the rotation, or in the buffer hand-off, corrupts the first or last bit of a period and shows up as a mismatch.

// File: rtl/survivor_tb_mem.sv
module survivor_tb_mem #(
  parameter int D  = 15,
  parameter int NS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step_en,
  input  logic [NS-1:0]         dec_vec,
  input  logic [$clog2(NS)-1:0] best_state,
  output logic                  out_bit,
  output logic                  out_valid
);
  localparam int SW = $clog2(NS);
  localparam int CW = $clog2(D);

  logic [NS-1:0] mem [0:2][0:D-1];
  logic [CW-1:0] col, rcol;
  logic [1:0]    rot, tbk, dbk, pc;
  logic [SW-1:0] tb, ds, tb_cur, ds_cur;
  logic [D-1:0]  fb, ob;
  logic          d_tb, d_dc, last;

  assign last   = (col == CW'(D-1));
  assign rcol   = CW'(D-1) - col;
  assign tbk    = (rot == 2'd0) ? 2'd2 : rot - 2'd1;
  assign dbk    = (rot == 2'd0) ? 2'd1 : (rot == 2'd1) ? 2'd2 : 2'd0;
  assign tb_cur = (col == '0) ? best_state : tb;
  assign ds_cur = (col == '0) ? tb : ds;
  assign d_tb   = mem[tbk][rcol][tb_cur];
  assign d_dc   = mem[dbk][rcol][ds_cur];

  always_ff @(posedge clk) begin
    if (step_en) mem[rot][col] <= dec_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0; rot <= '0; pc <= '0;
      tb <= '0; ds <= '0; fb <= '0; ob <= '0;
      out_bit <= 1'b0; out_valid <= 1'b0;
    end else begin
      out_valid <= step_en && (pc == 2'd3);
      if (step_en) begin
        tb <= {d_tb, tb_cur[SW-1:1]};
        ds <= {d_dc, ds_cur[SW-1:1]};
        fb[rcol] <= ds_cur[SW-1];
        out_bit <= ob[col];
        if (last) begin
          col <= '0;
          rot <= (rot == 2'd2) ? 2'd0 : rot + 2'd1;
          if (pc != 2'd3) pc <= pc + 2'd1;
          ob <= {fb[D-1:1], ds_cur[SW-1]};
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

  a_r1_quiet_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != 2'd3) |=> !out_valid);
  a_r2_strobe_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(step_en));
  a_r2_strobe_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && pc == 2'd3) |=> out_valid);
  a_r3_col_range: assert property (@(posedge clk) disable iff (!rst_n)
    col < CW'(D) && rot < 2'd3);
  a_r7_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && last) |=> (rot != $past(rot)) && (col == '0));
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(col) && $stable(rot) && $stable(tb) && $stable(ds) && !out_valid);
endmodule

// File: tb/test_survivor_tb_mem.sv
module test_survivor_tb_mem;
  localparam int D = 15;
  localparam int NP = 10;
  localparam int N = NP * D;

  logic clk = 0, rst_n = 0, step_en = 0;
  logic [3:0] dec_vec = '0;
  logic [1:0] best_state = '0;
  logic out_bit, out_valid;

  survivor_tb_mem #(.D(D), .NS(4)) i_survivor_tb_mem (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .dec_vec(dec_vec),
    .best_state(best_state), .out_bit(out_bit), .out_valid(out_valid));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cur_idx = 0, strobes = 0;
  bit done = 0, running = 0;
  logic [3:0] dec_h [N];
  logic [1:0] bst_h [N];
  logic       exp_b [N];
  logic       q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // monitor / scoreboard (R1, R2, R6, R8)
  always @(posedge clk) begin
    #2;
    if (running) begin
      chk(out_valid == (step_en && cur_idx >= 3*D), "R1/R2/R8 strobe", out_valid, step_en && cur_idx >= 3*D);
      if (out_valid) begin
        strobes++;
        if (q.size() == 0) chk(0, "R6 queue empty", 1, 0);
        else begin
          logic e;
          e = q.pop_front();
          chk(out_bit == e, "R4/R5/R6 decoded bit", out_bit, e);
        end
      end
    end
  end

  initial begin
    for (int n = 0; n < N; n++) begin
      int p;
      p = n / D;
      if (p < 3) begin dec_h[n] = 4'h0; bst_h[n] = 2'd0; end
      else if (p < 6) begin dec_h[n] = 4'($urandom); bst_h[n] = 2'($urandom); end
      else if (p < 8) begin dec_h[n] = 4'hF; bst_h[n] = 2'(n % 4); end
      else begin dec_h[n] = (n % 2) ? 4'b1010 : 4'b0101; bst_h[n] = 2'd3 - 2'(n % 4); end
      exp_b[n] = 1'b0;
    end
    for (int p = 0; p + 3 < NP; p++) begin
      logic [1:0] s;
      s = bst_h[(p+1)*D];
      for (int j = D-1; j >= 0; j--) s = {dec_h[p*D+j][s], s[1]};
      for (int j = D-1; j >= 0; j--) begin
        exp_b[(p+3)*D+j] = s[1];
        s = {dec_h[p*D+j][s], s[1]};
      end
    end

    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 reset valid", out_valid, 0);
    chk(out_bit == 0, "R1 reset bit", out_bit, 0);
    rst_n = 1;
    running = 1;
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      step_en = 1; dec_vec = dec_h[n]; best_state = bst_h[n]; cur_idx = n;
      if (n >= 3*D) q.push_back(exp_b[n]);
      if (n % 7 == 3) begin
        @(negedge clk);
        step_en = 0; dec_vec = ~dec_h[n]; best_state = ~bst_h[n];
      end
    end
    @(negedge clk);
    step_en = 0;
    repeat (3) @(negedge clk);
    running = 0;
    chk(strobes == N - 3*D, "R2 strobe count", strobes, N - 3*D);
    chk(q.size() == 0, "R6 leftover", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule